// File: doc/BRIEF.md
# Output Fault and Power-Good Supervisor

This block supervises one channel of a switching regulator in the digital domain. It takes comparator flags that already report the sensed output against fixed fractions of the set point: a low and a high edge of the regulation window, an over-voltage level and an under-voltage level. It also takes the enable, the supply-good status, the soft-start-complete status, an over-temperature flag and a latch request from the over-current logic. From these it produces the power-good flag, the gate requests for the high-side and low-side switches, the channel-run state and a one-cycle pulse that restarts the soft-start ramp.

Each comparator flag passes through its own time filter. The flag must be seen high on `FILT_CYC` consecutive clock edges before the block acts on it, and the filtered flag drops on the first edge that samples it low. Over-voltage is a soft crowbar. It forces the low-side switch on and the high-side switch off while the filtered flag stays high, and it releases without memory. Under-voltage is armed only once soft-start is complete. When it fires, it latches the channel off, and the over-current request does the same. Only an enable cycle, a supply loss or an over-temperature event clears the latch, and over-temperature acts as a full internal restart.

Top module: `pgsup_top`

## Requirements
- R1: `pg` is low in every cycle where the filtered window-low flag or the filtered window-high flag is high.
- R2: `pg` is high only while `run` is high, `ss_done` is high and neither filtered window flag is high.
- R3: A comparator flag takes effect after the clock edge that samples it high for the `FILT_CYC`-th consecutive time. A sampled low clears the filtered flag at that edge and restarts the count.
- R4: While the filtered over-voltage flag is high, `force_ls` and `ls_on` are high and `hs_on` is low. All three follow the request inputs again after the edge where the filtered flag drops, with no latching.
- R5: The latch sets at the edge that samples both the filtered under-voltage flag and `ss_done` high, with `en` high. `run` and `pg` then go low at once. While `ss_done` is low, under-voltage has no effect.
- R6: A high `ocp_latch` sampled at an edge, with `en` high, sets the same latch.
- R7: A set latch holds `run` low until an edge samples `en` low, or until `vcc_ok` goes low. Removing the fault does not clear it.
- R8: An edge that samples `ot_flag` high drives `run` low and clears the latch. The edge that first samples `ot_flag` low again lets `run` return.
- R9: `ss_restart` is high for exactly the first cycle of each interval in which `run` is high.
- R10: `hs_on` equals `run & hs_req` unless the crowbar is active. `ls_on` equals `run & ls_req & ~hs_req` unless the crowbar is active. `hs_on` and `ls_on` are never both high.
- R11: While `vcc_ok` is low, every output is low and all filter counts and state are cleared asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| vcc_ok | input | 1 | Supply above lockout; low is an asynchronous power-on reset |
| en | input | 1 | Channel enable |
| ss_done | input | 1 | Soft-start ramp has completed |
| ot_flag | input | 1 | Over-temperature detected |
| win_lo | input | 1 | Output below lower edge of regulation window |
| win_hi | input | 1 | Output above upper edge of regulation window |
| ov_cmp | input | 1 | Output above over-voltage level |
| uv_cmp | input | 1 | Output below under-voltage level |
| ocp_latch | input | 1 | Latch request from over-current logic |
| hs_req | input | 1 | High-side drive request from the modulator |
| ls_req | input | 1 | Low-side drive request from the modulator |
| pg | output | 1 | Power good, high when good (models release of an open-drain pull-down) |
| force_ls | output | 1 | Over-voltage crowbar active |
| hs_on | output | 1 | High-side gate request after supervision |
| ls_on | output | 1 | Low-side gate request after supervision |
| run | output | 1 | Channel allowed to switch |
| ss_restart | output | 1 | One-cycle pulse to restart the soft-start ramp |

## Verification
The assertions assume that all inputs are synchronous to `clk` and change only away from its rising edge. They also assume that `vcc_ok` starts low, so that reset covers the first edges. The stimulus drives every input on the falling edge and holds `vcc_ok` low for the opening cycles. The bench pulses `vcc_ok` low only between edges. Comparator glitches one cycle shorter than the filter window are driven on purpose, and so are held faults, to probe both sides of each filter.

// File: rtl/pgsup_pkg.sv
package pgsup_pkg;
   // comparator lanes, in filter array order
   localparam int N_CMP  = 4;
   localparam int CMP_LO = 0;
   localparam int CMP_HI = 1;
   localparam int CMP_OV = 2;
   localparam int CMP_UV = 3;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/pgsup_filt.sv
module pgsup_filt #(
   parameter int unsigned FILT_CYC = 8
) (
   input  logic clk,
   input  logic vcc_ok,
   input  logic raw,
   output logic flt
);
   import pgsup_pkg::*;
   localparam int unsigned CW = cnt_width(FILT_CYC);

   generate
      if (FILT_CYC < 1) begin : g_bad_len
         $error("pgsup_filt: FILT_CYC must be at least 1");
      end
      if (FILT_CYC == 1) begin : g_pass
         always_ff @(posedge clk or negedge vcc_ok) begin
            if (!vcc_ok) flt <= 1'b0;
            else         flt <= raw;
         end
      end else begin : g_count
         localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge vcc_ok) begin
            if (!vcc_ok) begin
               cnt <= '0;
               flt <= 1'b0;
            end else if (!raw) begin
               cnt <= '0;
               flt <= 1'b0;
            end else if (cnt == LAST) begin
               flt <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/pgsup_fault.sv
module pgsup_fault (
   input  logic clk,
   input  logic vcc_ok,
   input  logic en,
   input  logic ot_flag,
   input  logic ss_done,
   input  logic uv_flt,
   input  logic ocp_latch,
   output logic run,
   output logic ss_restart,
   output logic latched
);
   logic ot_q;
   logic run_prev;

   always_ff @(posedge clk or negedge vcc_ok) begin
      if (!vcc_ok) begin
         ot_q     <= 1'b0;
         run_prev <= 1'b0;
         latched  <= 1'b0;
      end else begin
         ot_q     <= ot_flag;
         run_prev <= run;
         if (!en || ot_q)
            latched <= 1'b0;
         else if ((uv_flt && ss_done) || ocp_latch)
            latched <= 1'b1;
      end
   end

   assign run        = vcc_ok & en & ~latched & ~ot_q;
   assign ss_restart = run & ~run_prev;
endmodule

// File: rtl/pgsup_out.sv
module pgsup_out (
   input  logic vcc_ok,
   input  logic run,
   input  logic ss_done,
   input  logic lo_flt,
   input  logic hi_flt,
   input  logic ov_flt,
   input  logic hs_req,
   input  logic ls_req,
   output logic pg,
   output logic force_ls,
   output logic hs_on,
   output logic ls_on
);
   always_comb begin
      force_ls = vcc_ok & ov_flt;
      pg       = run & ss_done & ~lo_flt & ~hi_flt;
      hs_on    = run & hs_req & ~force_ls;
      ls_on    = force_ls | (run & ls_req & ~hs_req);
   end
endmodule

// File: rtl/pgsup_top.sv
module pgsup_top #(
   parameter int unsigned FILT_CYC = 8
) (
   input  logic clk,
   input  logic vcc_ok,
   input  logic en,
   input  logic ss_done,
   input  logic ot_flag,
   input  logic win_lo,
   input  logic win_hi,
   input  logic ov_cmp,
   input  logic uv_cmp,
   input  logic ocp_latch,
   input  logic hs_req,
   input  logic ls_req,
   output logic pg,
   output logic force_ls,
   output logic hs_on,
   output logic ls_on,
   output logic run,
   output logic ss_restart
);
   import pgsup_pkg::*;

   logic [N_CMP-1:0] cmp_raw;
   logic [N_CMP-1:0] cmp_flt;
   logic             uv_flt;
   logic             ov_flt;
   logic             latched;

   generate
      if (FILT_CYC < 1) begin : g_bad_len
         $error("pgsup_top: FILT_CYC must be at least 1");
      end
   endgenerate

   always_comb begin
      cmp_raw         = '0;
      cmp_raw[CMP_LO] = win_lo;
      cmp_raw[CMP_HI] = win_hi;
      cmp_raw[CMP_OV] = ov_cmp;
      cmp_raw[CMP_UV] = uv_cmp;
   end

   genvar gi;
   generate
      for (gi = 0; gi < N_CMP; gi++) begin : g_filt
         pgsup_filt #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk    (clk),
            .vcc_ok (vcc_ok),
            .raw    (cmp_raw[gi]),
            .flt    (cmp_flt[gi])
         );
      end
   endgenerate

   assign uv_flt = cmp_flt[CMP_UV];
   assign ov_flt = cmp_flt[CMP_OV];

   pgsup_fault u_fault (
      .clk        (clk),
      .vcc_ok     (vcc_ok),
      .en         (en),
      .ot_flag    (ot_flag),
      .ss_done    (ss_done),
      .uv_flt     (uv_flt),
      .ocp_latch  (ocp_latch),
      .run        (run),
      .ss_restart (ss_restart),
      .latched    (latched)
   );

   pgsup_out u_out (
      .vcc_ok   (vcc_ok),
      .run      (run),
      .ss_done  (ss_done),
      .lo_flt   (cmp_flt[CMP_LO]),
      .hi_flt   (cmp_flt[CMP_HI]),
      .ov_flt   (ov_flt),
      .hs_req   (hs_req),
      .ls_req   (ls_req),
      .pg       (pg),
      .force_ls (force_ls),
      .hs_on    (hs_on),
      .ls_on    (ls_on)
   );
endmodule

// File: rtl/pgsup_chk.sv
module pgsup_chk (
   input logic clk,
   input logic vcc_ok,
   input logic en,
   input logic ss_done,
   input logic ov_cmp,
   input logic ov_flt,
   input logic uv_flt,
   input logic ot_q,
   input logic latched,
   input logic run,
   input logic pg,
   input logic hs_on,
   input logic ls_on,
   input logic ss_restart
);
   p_drv_excl_r10: assert property (@(posedge clk) disable iff (!vcc_ok)
      !(hs_on && ls_on));
   p_ov_force_r4: assert property (@(posedge clk) disable iff (!vcc_ok)
      ov_flt |-> (ls_on && !hs_on));
   p_ov_filter_r3: assert property (@(posedge clk) disable iff (!vcc_ok)
      $rose(ov_flt) |-> $past(ov_cmp));
   p_pg_gate_r2: assert property (@(posedge clk) disable iff (!vcc_ok)
      pg |-> (ss_done && run));
   p_latch_off_r5: assert property (@(posedge clk) disable iff (!vcc_ok)
      latched |-> (!run && !pg));
   p_uv_latch_r5: assert property (@(posedge clk) disable iff (!vcc_ok)
      (uv_flt && ss_done && en && !ot_q) |=> latched);
   p_latch_hold_r7: assert property (@(posedge clk) disable iff (!vcc_ok)
      (latched && en && !ot_q) |=> latched);
   p_restart_run_r9: assert property (@(posedge clk) disable iff (!vcc_ok)
      ss_restart |-> run);
   p_restart_once_r9: assert property (@(posedge clk) disable iff (!vcc_ok)
      ss_restart |=> !ss_restart);
endmodule

bind pgsup_top pgsup_chk u_chk (
   .clk        (clk),
   .vcc_ok     (vcc_ok),
   .en         (en),
   .ss_done    (ss_done),
   .ov_cmp     (ov_cmp),
   .ov_flt     (ov_flt),
   .uv_flt     (uv_flt),
   .ot_q       (u_fault.ot_q),
   .latched    (latched),
   .run        (run),
   .pg         (pg),
   .hs_on      (hs_on),
   .ls_on      (ls_on),
   .ss_restart (ss_restart)
);

// File: tb/tb_pgsup_top.sv
module tb_pgsup_top;
   localparam int CLK_PERIOD = 10;
   localparam int FC         = 4;
   localparam int MAX_CYC    = 20000;

   logic clk = 1'b0;
   logic vcc_ok = 1'b0, en = 1'b0, ss_done = 1'b0, ot_flag = 1'b0;
   logic win_lo = 1'b0, win_hi = 1'b0, ov_cmp = 1'b0, uv_cmp = 1'b0;
   logic ocp_latch = 1'b0, hs_req = 1'b0, ls_req = 1'b0;
   logic pg, force_ls, hs_on, ls_on, run, ss_restart;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pgsup_top #(.FILT_CYC(FC)) dut (
      .clk(clk), .vcc_ok(vcc_ok), .en(en), .ss_done(ss_done), .ot_flag(ot_flag),
      .win_lo(win_lo), .win_hi(win_hi), .ov_cmp(ov_cmp), .uv_cmp(uv_cmp),
      .ocp_latch(ocp_latch), .hs_req(hs_req), .ls_req(ls_req),
      .pg(pg), .force_ls(force_ls), .hs_on(hs_on), .ls_on(ls_on),
      .run(run), .ss_restart(ss_restart)
   );

   // behavioural reference state
   int  m_cnt [4];
   bit  m_flt [4];
   bit  m_lat, m_ot, m_was_run;

   function automatic bit m_run();
      return vcc_ok && en && !m_lat && !m_ot;
   endfunction

   always @(posedge clk or negedge vcc_ok) begin
      if (!vcc_ok) begin
         for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_flt[i] = 0; end
         m_lat = 0; m_ot = 0; m_was_run = 0;
      end else begin
         bit r_now, nl;
         bit raw [4];
         r_now = m_run();
         raw[0] = win_lo; raw[1] = win_hi; raw[2] = ov_cmp; raw[3] = uv_cmp;
         if (!en || m_ot) nl = 0;
         else if ((m_flt[3] && ss_done) || ocp_latch) nl = 1;
         else nl = m_lat;
         for (int i = 0; i < 4; i++) begin
            if (!raw[i]) begin m_cnt[i] = 0; m_flt[i] = 0; end
            else if (m_cnt[i] >= FC - 1) m_flt[i] = 1;
            else m_cnt[i]++;
         end
         m_ot = ot_flag; m_was_run = r_now; m_lat = nl;
      end
   end

   task automatic chk(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s at cycle %0d: actual=%b expected=%b", tag, cyc, act, exp);
      end
   endtask

   task automatic compare();
      bit r, frc;
      r   = m_run();
      frc = vcc_ok && m_flt[2];
      chk("R11 run", run, r);
      chk("R1 R2 pg", pg, r && ss_done && !m_flt[0] && !m_flt[1]);
      chk("R4 force_ls", force_ls, frc);
      chk("R10 hs_on", hs_on, r && hs_req && !frc);
      chk("R10 ls_on", ls_on, frc || (r && ls_req && !hs_req));
      chk("R9 ss_restart", ss_restart, r && !m_was_run);
   endtask

   task automatic tick(input int n = 1);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         @(negedge clk);
         compare();
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > MAX_CYC) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R11: reset state
      en = 1'b1; hs_req = 1'b1;
      tick(3);
      chk("R11 reset pg", pg, 1'b0);
      chk("R11 reset run", run, 1'b0);
      chk("R11 reset hs_on", hs_on, 1'b0);
      vcc_ok = 1'b1;
      #1 chk("R9 first restart", ss_restart, 1'b1);
      tick(2);
      chk("R2 pg waits for soft-start", pg, 1'b0);
      ss_done = 1'b1;
      tick(1);
      chk("R2 pg after soft-start", pg, 1'b1);

      // R3: glitch one short of the window is ignored, full window acts (R1)
      win_lo = 1'b1; tick(FC - 1);
      chk("R3 short glitch ignored", pg, 1'b1);
      win_lo = 1'b0; tick(1);
      win_lo = 1'b1; tick(FC);
      chk("R1 window low drops pg", pg, 1'b0);
      win_lo = 1'b0; tick(1);
      chk("R3 drop clears at once", pg, 1'b1);
      win_hi = 1'b1; tick(FC);
      chk("R1 window high drops pg", pg, 1'b0);
      win_hi = 1'b0; tick(1);

      // R10: request arbitration
      hs_req = 1'b0; ls_req = 1'b1; tick(1);
      chk("R10 ls passes", ls_on, 1'b1);
      hs_req = 1'b1; tick(1);
      chk("R10 hs wins", ls_on, 1'b0);

      // R4: crowbar overrides requests and releases without memory
      ov_cmp = 1'b1; tick(FC);
      chk("R4 crowbar ls", ls_on, 1'b1);
      chk("R4 crowbar hs off", hs_on, 1'b0);
      ov_cmp = 1'b0; tick(1);
      chk("R4 crowbar released", force_ls, 1'b0);
      chk("R4 hs resumes", hs_on, 1'b1);

      // R5: under-voltage masked during soft-start
      ss_done = 1'b0; uv_cmp = 1'b1; tick(FC + 4);
      chk("R5 masked during soft-start", run, 1'b1);
      uv_cmp = 1'b0; tick(1); ss_done = 1'b1; tick(1);
      uv_cmp = 1'b1; tick(FC);
      chk("R5 not yet latched", run, 1'b1);
      tick(1);
      chk("R5 latched off", run, 1'b0);
      uv_cmp = 1'b0; tick(5);
      chk("R7 latch holds", run, 1'b0);
      en = 1'b0; tick(1);
      en = 1'b1;
      #1 chk("R9 restart after toggle", ss_restart, 1'b1);
      tick(1);
      chk("R7 enable toggle clears", run, 1'b1);

      // R6: over-current latch request, cleared by supply loss (R11)
      ocp_latch = 1'b1; tick(1);
      ocp_latch = 1'b0;
      chk("R6 ocp latch", run, 1'b0);
      tick(3);
      chk("R7 ocp latch holds", run, 1'b0);
      vcc_ok = 1'b0; #1;
      chk("R11 supply loss outputs", force_ls | run | pg, 1'b0);
      tick(1);
      vcc_ok = 1'b1; tick(2);
      chk("R7 supply cycle clears", run, 1'b1);

      // R8: over-temperature restart clears a latch
      ocp_latch = 1'b1; tick(1); ocp_latch = 1'b0;
      ot_flag = 1'b1; tick(3);
      chk("R8 off during ot", run, 1'b0);
      ot_flag = 1'b0; tick(1);
      chk("R8 resumes after ot", run, 1'b1);
      chk("R9 restart after ot", ss_restart, 1'b1);
      tick(1);
      chk("R9 pulse is single", ss_restart, 1'b0);

      // mixed activity
      for (int i = 0; i < 60; i++) begin
         hs_req = i[0]; ls_req = ~i[0];
         ov_cmp = (i % 13) < 6;
         win_hi = (i % 7) < 5;
         tick(1);
      end
      ov_cmp = 1'b0; win_hi = 1'b0; tick(FC);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule